// File: doc/BRIEF.md
# Read-Only Serial Bus Target for a Stored Payload

This block is a two-wire serial bus (I2C) target that can only transmit. It sits next to a small store that holds a fixed number of data bytes, five by default. A controller on the bus addresses the block for a read. The block acknowledges and then returns the stored bytes one after another. Each byte leaves most significant bit first. Any byte requested beyond the stored ones reads as 0xFF for as long as the controller keeps asking. The block never accepts written data. It never holds the clock low, and it does not take part in arbitration.

A strap input selects one of two bus addresses. The bus clock and data lines are synchronized into the local clock domain, and all bus events are decoded from the synchronized copies. The block outputs one-cycle pulses for start and stop conditions, a busy flag, and a read-complete strobe. The neighbouring buffer logic uses these to time the hand-over of fresh data.

Top module: `rdi2c_target`

## Requirements
- R1: While `rst_n` is low, `sda_oe` stays 0 and no address is acknowledged. `busy` is 0 after reset.
- R2: When `addr_strap` is 0, the block acknowledges the address byte 0x23. When `addr_strap` is 1, it acknowledges 0x21. Bit 0 of the address byte is the read flag. The block acknowledges by pulling SDA low for the ninth clock of that byte.
- R3: The block does not acknowledge an address byte with any other value, including the matching address with the read flag at 0. After such a byte `busy` returns to 0.
- R4: Data bits leave most significant bit first. `sda_oe` changes only while SCL is low.
- R5: Byte k of a transfer (k = 0 first) is `payload_i[8k+7:8k]` for k below NBYTES. Every later byte is 0xFF.
- R6: A non-acknowledge from the controller releases SDA and returns the block to idle (`busy` 0) until the next start. A stop condition does the same.
- R7: A start condition at any bit position aborts the current byte and begins a fresh address phase.
- R8: `start_evt` and `stop_evt` pulse for one cycle for each start or stop condition on the bus. They are never high together.
- R9: `read_done` pulses once, one cycle after a stop, but only if at least one stored byte was sent since the previous stop. An address-only transaction gives no pulse.
- R10: `busy` rises the cycle after a start condition and stays high through the address phase and the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_strap | input | 1 | Address select strap (0: 0x23, 1: 0x21) |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain drive) |
| payload_i | input | NBYTES*8 | Stored bytes, byte k at bits 8k+7:8k |
| start_evt | output | 1 | One-cycle pulse on a start condition |
| stop_evt | output | 1 | One-cycle pulse on a stop condition |
| busy | output | 1 | Transaction in progress |
| read_done | output | 1 | One-cycle pulse when a read that sent stored data closes |

## Verification
The hardest case to reach is a start condition that arrives partway through an address byte while the shift counter is mid-count. It is followed at once by a full address that must still be accepted. The bench bit-bangs the bus itself, so it can issue four address bits, re-raise the data line and drop it again with the clock high. Reads that run past the stored bytes, and an address-only transaction closed by a stop, cover the 0xFF padding and the absence of the read-complete strobe.

// File: rtl/rdi2c_pkg.sv
package rdi2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_TX,
    ST_MACK
  } tgt_state_e;

  // Full address byte seen on the wire for a read of the given 7-bit address
  function automatic logic [7:0] read_addr_byte(input logic [6:0] a7);
    return {a7, 1'b1};
  endfunction

  // Open-drain drive for a data bit: pull low only for a zero
  function automatic logic drive_for_bit(input logic b);
    return ~b;
  endfunction

endpackage

// File: rtl/rdi2c_sync.sv
module rdi2c_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= '1;
        else        pipe[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= '1;
        else        pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/rdi2c_linecond.sv
module rdi2c_linecond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/rdi2c_byte_src.sv
module rdi2c_byte_src #(
  parameter int NBYTES = 5,
  localparam int IDXW  = $clog2(NBYTES + 1)
) (
  input  logic [NBYTES*8-1:0] payload_i,
  input  logic [IDXW-1:0]     idx_i,
  output logic [7:0]          byte_o
);
  logic [7:0] slot [NBYTES+1];

  for (genvar k = 0; k < NBYTES; k++) begin : g_slot
    assign slot[k] = payload_i[8*k +: 8];
  end
  assign slot[NBYTES] = 8'hFF;

  always_comb begin
    byte_o = 8'hFF;
    for (int k = 0; k <= NBYTES; k++)
      if (idx_i == IDXW'(k)) byte_o = slot[k];
  end
endmodule

// File: rtl/rdi2c_target.sv
module rdi2c_target
  import rdi2c_pkg::*;
#(
  parameter int         NBYTES       = 5,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [6:0] ADDR_STRAP_LO = 7'h11,
  parameter logic [6:0] ADDR_STRAP_HI = 7'h10,
  localparam int        IDXW         = $clog2(NBYTES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_strap,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe,
  input  logic [NBYTES*8-1:0] payload_i,
  output logic                start_evt,
  output logic                stop_evt,
  output logic                busy,
  output logic                read_done
);
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_c, stop_c;
  tgt_state_e state;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic [IDXW-1:0] idx;
  logic       sent_any, nack_q;
  logic [7:0] cur_byte;
  logic [7:0] my_addr;

  rdi2c_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  rdi2c_linecond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
  );

  rdi2c_byte_src #(.NBYTES(NBYTES)) u_src (
    .payload_i(payload_i), .idx_i(idx), .byte_o(cur_byte)
  );

  assign my_addr = read_addr_byte(addr_strap ? ADDR_STRAP_HI : ADDR_STRAP_LO);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      idx       <= '0;
      sent_any  <= 1'b0;
      nack_q    <= 1'b0;
      sda_oe    <= 1'b0;
      read_done <= 1'b0;
    end else begin
      read_done <= 1'b0;
      if (start_c) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        idx     <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_c) begin
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
        read_done <= sent_any;
        sent_any  <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (shreg == my_addr) begin
                state  <= ST_AACK;
                sda_oe <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              state   <= ST_TX;
              bit_cnt <= '0;
              sda_oe  <= drive_for_bit(cur_byte[7]);
              shreg   <= {cur_byte[6:0], 1'b0};
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                state  <= ST_MACK;
                sda_oe <= 1'b0;
                if (idx < IDXW'(NBYTES)) begin
                  sent_any <= 1'b1;
                  idx      <= idx + 1'b1;
                end
              end else begin
                sda_oe <= drive_for_bit(shreg[7]);
                shreg  <= {shreg[6:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (nack_q) begin
                state <= ST_IDLE;
              end else begin
                state   <= ST_TX;
                bit_cnt <= '0;
                sda_oe  <= drive_for_bit(cur_byte[7]);
                shreg   <= {cur_byte[6:0], 1'b0};
              end
            end
          end
          default: ;
        endcase
      end
    end

  assign busy      = (state != ST_IDLE);
  assign start_evt = start_c;
  assign stop_evt  = stop_c;
endmodule

// File: rtl/rdi2c_target_chk.sv
module rdi2c_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic start_evt,
  input logic stop_evt,
  input logic busy,
  input logic read_done
);
  // R1
  always_comb
    if (!rst_n) a_r1_quiet_in_reset: assert (!sda_oe);

  a_r4_oe_moves_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  a_r2_drive_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> busy);

  a_r6_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!busy && !sda_oe));

  a_r8_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_evt && stop_evt));

  a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !start_evt);

  a_r9_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    read_done |-> $past(stop_evt));

  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);
endmodule

bind rdi2c_target rdi2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .busy(busy), .read_done(read_done)
);

// File: tb/rdi2c_target_tb.sv
module rdi2c_target_tb;
  localparam int NB = 5;
  localparam int Q  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe, start_evt, stop_evt, busy, read_done;
  logic [NB*8-1:0] payload;
  wire  sda = ~(m_low | sda_oe);

  int tests = 0, fails = 0;
  int n_start = 0, n_stop = 0, n_done = 0;
  int exp_start = 0, exp_stop = 0, exp_done = 0;
  int scl_hi = 0;
  logic oe_prev = 1'b0;
  logic [7:0] store [NB] = '{8'hA5, 8'h3C, 8'h00, 8'h7E, 8'h81};
  bit finished = 0;

  always #4 clk = ~clk;

  for (genvar k = 0; k < NB; k++) begin : g_pay
    assign payload[8*k +: 8] = store[k];
  end

  rdi2c_target #(.NBYTES(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_strap(strap), .scl_i(scl), .sda_i(sda),
    .sda_oe(sda_oe), .payload_i(payload), .start_evt(start_evt),
    .stop_evt(stop_evt), .busy(busy), .read_done(read_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock observation: event pulses and data-line stability while clock high
  always @(negedge clk) begin
    if (start_evt) n_start++;
    if (stop_evt)  n_stop++;
    if (read_done) n_done++;
    if (rst_n && sda_oe != oe_prev)
      check(!(scl && scl_hi > 4), "R4 oe change while clock high", scl_hi, 0);
    oe_prev = sda_oe;
    scl_hi = scl ? scl_hi + 1 : 0;
  end

  function automatic logic [7:0] exp_byte(input int k);
    return (k < NB) ? store[k] : 8'hFF;
  endfunction

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(Q); scl = 1'b1; wq(Q); m_low = 1'b1; wq(Q); scl = 1'b0; wq(Q);
    if (rst_n) exp_start++;
  endtask

  task automatic bus_stop();
    scl = 1'b0; m_low = 1'b1; wq(Q); scl = 1'b1; wq(Q); m_low = 1'b0; wq(Q);
    if (rst_n) exp_stop++;
  endtask

  task automatic send_bit(input logic b);
    scl = 1'b0; m_low = ~b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
  endtask

  task automatic recv_bit(output logic b);
    scl = 1'b0; m_low = 1'b0; wq(Q); scl = 1'b1; wq(Q); b = sda; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic write_byte(input logic [7:0] v, output logic ack_line);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(ack_line);
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(give_ack ? 1'b0 : 1'b1);
  endtask

  // full read: address, n bytes, last one non-acknowledged, then stop
  task automatic do_read(input logic [7:0] addr, input int n, input string tag);
    logic a;
    logic [7:0] v;
    bus_start();
    write_byte(addr, a);
    check(a == 1'b0, {tag, " R2 address acknowledged"}, a, 0);
    check(busy == 1'b1, "R10 busy during transfer", busy, 1);
    for (int k = 0; k < n; k++) begin
      read_byte(k != n - 1, v);
      check(v == exp_byte(k), (k < NB) ? "R4 R5 stored byte" : "R5 padding byte", v, exp_byte(k));
    end
    check(busy == 1'b0 && sda == 1'b1, "R6 idle after non-acknowledge", busy, 0);
    bus_stop();
    exp_done++;
    wq(4);
    check(n_done == exp_done, "R9 read_done after stop", n_done, exp_done);
  endtask

  task automatic reject(input logic [7:0] addr, input string tag);
    logic a;
    bus_start();
    write_byte(addr, a);
    check(a == 1'b1, {tag, " R3 no acknowledge"}, a, 1);
    check(busy == 1'b0, "R3 idle after mismatch", busy, 0);
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] v;
    wq(4);
    check(sda_oe == 1'b0 && busy == 1'b0, "R1 reset state", {sda_oe, busy}, 0);
    bus_start();
    write_byte(8'h23, a);
    check(a == 1'b1, "R1 no acknowledge in reset", a, 1);
    bus_stop();
    rst_n = 1'b1;
    wq(4);

    do_read(8'h23, 7, "strap0");
    reject(8'h21, "strap0 other");
    reject(8'h22, "write flag");

    strap = 1'b1;
    wq(4);
    do_read(8'h21, 2, "strap1");
    reject(8'h23, "strap1 other");

    // R7: abort after four address bits with a repeated start
    bus_start();
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    write_byte(8'h21, a);
    check(a == 1'b0, "R7 address after abort", a, 0);
    read_byte(1'b0, v);
    check(v == exp_byte(0), "R7 first byte after abort", v, exp_byte(0));
    bus_stop();
    exp_done++;
    wq(4);
    check(n_done == exp_done, "R9 read_done after aborted start", n_done, exp_done);

    // R9: address-only transaction gives no strobe (first stored bit is 1, line free)
    bus_start();
    write_byte(8'h21, a);
    check(a == 1'b0, "R2 address-only acknowledged", a, 0);
    check(busy == 1'b1, "R10 busy before data", busy, 1);
    bus_stop();
    wq(4);
    check(n_done == exp_done, "R9 no strobe without data", n_done, exp_done);
    check(busy == 1'b0 && sda_oe == 1'b0, "R6 idle after stop", busy, 0);

    check(n_start == exp_start, "R8 start pulses", n_start, exp_start);
    check(n_stop == exp_stop, "R8 stop pulses", n_stop, exp_stop);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule